// File: doc/BRIEF.md
# NAND Command and Address Decoder

This block is the device-side front end of a small-page NAND memory with an 8-bit bus that carries commands, addresses and data. It watches the write-enable strobe and looks for its rising edge in the system clock domain. On each qualified edge it sends the byte to the command decoder when the command-latch line is high, or to the address collector when the address-latch line is high. It tracks the multi-cycle command sequences for read, program, copy-back and erase. It builds the column and row address from the right number of address cycles. It also keeps a read-area pointer that selects the first half, the second half or the spare area of a 528-byte page.

When a sequence completes, the block gives a one-cycle start strobe together with the decoded operation, the area pointer and the assembled address. The array engine behind it uses these to begin the operation. While the engine reports busy, the block accepts only the reset and status commands.

Top module: `nand_cmd_front`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `op_start` is low, and `op_area` reads 0 (first half).
- R2: Opcode 00h, 01h or 50h, followed by three address bytes (column, low row, high row), pulses `op_start` with `op_code`=1 (read) on the cycle after the third address edge. `op_col` equals the column byte and `op_row` equals {high, low}. `op_area` is 0 for 00h, 1 for 01h and 2 for 50h. The area stays set until another area command or a reset.
- R3: 80h, then three address bytes, then any number of data bytes (both latch lines low), then 10h, pulses `op_start` with `op_code`=2 (program) and the collected address. Data bytes start nothing.
- R4: 60h, then two address bytes (low row, high row), then D0h, pulses `op_start` with `op_code`=4 (erase), `op_row`={high, low} and `op_col`=0.
- R5: 8Ah given right after a completed 00h read sequence pulses `op_start` with `op_code`=3 (copy-back) and that read's address.
- R6: FFh pulses `op_code`=6 (reset) and returns `op_area` to 0. 70h pulses `op_code`=7 (status). 90h pulses `op_code`=5 (read ID). Each is issued on the cycle after its edge.
- R7: While `busy` is high, only FFh and 70h start an operation. Other command bytes, address bytes and `ce_n` high leave the sequence state unchanged.
- R8: Address bytes beyond the number a sequence needs are ignored.
- R9: An undefined opcode, or a confirm byte (10h, D0h, 8Ah) without its matching setup, returns the decoder to idle and starts nothing.
- R10: `ce_n` high while not busy aborts a partly entered sequence.
- R11: Bytes are taken only on a `we_n` rising edge with `ce_n` low. A byte with both latch lines high is ignored. `op_start` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command-latch select |
| ale | input | 1 | Address-latch select |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| io_in | input | 8 | Bus byte |
| busy | input | 1 | Array engine busy |
| op_start | output | 1 | One-cycle operation start |
| op_code | output | 3 | Operation: 1 read, 2 program, 3 copy-back, 4 erase, 5 read ID, 6 reset, 7 status |
| op_area | output | 2 | Read-area pointer: 0 first half, 1 second half, 2 spare |
| op_col | output | 8 | Column address |
| op_row | output | ROW_BYTES*8 | Row (page) address |

## Verification
The checks assume that `we_n` is sampled by the system clock. They also assume it stays low for at least one clock before each rising edge, so two byte edges can never fall on adjacent cycles. The bus, `ce_n`, the latch lines and `busy` are assumed stable at the clock edge that sees the rise. The bench holds each byte for two clocks, drives every input on the falling clock edge, and changes `busy` and `ce_n` only between bytes. The random sequences use only defined opcodes in legal order, and the directed cases cover orphans, undefined opcodes and aborts.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_READ = 3'd1, OP_PROG = 3'd2, OP_COPY = 3'd3,
    OP_ERASE = 3'd4, OP_RDID = 3'd5, OP_RESET = 3'd6, OP_STAT = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    AR_LOW = 2'd0, AR_HIGH = 2'd1, AR_SPARE = 2'd2
  } area_e;

  typedef enum logic [3:0] {
    CK_UNDEF, CK_RD_LOW, CK_RD_HIGH, CK_RD_SPARE, CK_PG_SETUP, CK_PG_GO,
    CK_CB_GO, CK_ER_SETUP, CK_ER_GO, CK_ID, CK_RST, CK_STAT
  } cmd_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_DATA, SQ_ECONF} seq_e;
  typedef enum logic [1:0] {MD_READ, MD_PROG, MD_ERASE} mode_e;
endpackage

// File: rtl/nfe_bus_sampler.sv
module nfe_bus_sampler (
  input  logic clk,
  input  logic rst,
  input  logic ce_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  output logic cmd_hit,
  output logic addr_hit
);
  logic we_d;
  logic edge_ok;

  always_ff @(posedge clk) begin
    if (rst) we_d <= 1'b1;
    else     we_d <= we_n;
  end

  assign edge_ok  = we_n & ~we_d & ~ce_n;
  assign cmd_hit  = edge_ok & cle & ~ale;
  assign addr_hit = edge_ok & ale & ~cle;
endmodule

// File: rtl/nfe_opcode_decoder.sv
module nfe_opcode_decoder
  import nfe_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode,
  output cmd_e              kind
);
  always_comb begin
    case (opcode)
      8'h00:   kind = CK_RD_LOW;
      8'h01:   kind = CK_RD_HIGH;
      8'h50:   kind = CK_RD_SPARE;
      8'h80:   kind = CK_PG_SETUP;
      8'h10:   kind = CK_PG_GO;
      8'h8A:   kind = CK_CB_GO;
      8'h60:   kind = CK_ER_SETUP;
      8'hD0:   kind = CK_ER_GO;
      8'h90:   kind = CK_ID;
      8'hFF:   kind = CK_RST;
      8'h70:   kind = CK_STAT;
      default: kind = CK_UNDEF;
    endcase
  end
endmodule

// File: rtl/nfe_addr_collect.sv
module nfe_addr_collect
  import nfe_pkg::*;
#(
  parameter int ROW_BYTES = 2,
  localparam int ROW_W = ROW_BYTES * BYTE_W,
  localparam int IDX_W = $clog2(ROW_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ld,
  input  logic [IDX_W-1:0]  slot,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] col,
  output logic [ROW_W-1:0]  row
);
  // slot 0 is the column byte, slot k is row byte k-1 (least significant first)
  always_ff @(posedge clk) begin
    if (rst || clr)              col <= '0;
    else if (ld && slot == '0)   col <= din;
  end

  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst || clr)
        row[g*BYTE_W +: BYTE_W] <= '0;
      else if (ld && slot == IDX_W'(g + 1))
        row[g*BYTE_W +: BYTE_W] <= din;
    end
  end
endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
  import nfe_pkg::*;
#(
  parameter int ROW_BYTES = 2,
  localparam int ROW_W = ROW_BYTES * BYTE_W,
  localparam int IDX_W = $clog2(ROW_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              we_n,
  input  logic [BYTE_W-1:0] io_in,
  input  logic              busy,
  output logic              op_start,
  output logic [2:0]        op_code,
  output logic [1:0]        op_area,
  output logic [BYTE_W-1:0] op_col,
  output logic [ROW_W-1:0]  op_row
);
  logic cmd_hit, addr_hit;
  cmd_e kind;
  seq_e seq;
  mode_e mode;
  area_e ptr;
  op_e op_q;
  logic start_q;
  logic [IDX_W-1:0] cnt, slot;
  logic cb_ok, from_low, addr_ld, addr_clr, last_slot;

  nfe_bus_sampler i_smp (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .cmd_hit(cmd_hit), .addr_hit(addr_hit)
  );

  nfe_opcode_decoder i_dec (.opcode(io_in), .kind(kind));

  assign slot      = cnt + IDX_W'(mode == MD_ERASE);
  assign last_slot = (slot == IDX_W'(ROW_BYTES));
  assign addr_ld   = addr_hit & ~busy & (seq == SQ_ADDR);
  assign addr_clr  = cmd_hit & ~busy &
                     (kind inside {CK_RD_LOW, CK_RD_HIGH, CK_RD_SPARE, CK_PG_SETUP, CK_ER_SETUP});

  nfe_addr_collect #(.ROW_BYTES(ROW_BYTES)) i_adr (
    .clk(clk), .rst(rst), .clr(addr_clr), .ld(addr_ld), .slot(slot),
    .din(io_in), .col(op_col), .row(op_row)
  );

  always_ff @(posedge clk) begin
    start_q <= 1'b0;
    op_q    <= OP_NONE;
    if (rst) begin
      seq <= SQ_IDLE; mode <= MD_READ; ptr <= AR_LOW;
      cnt <= '0; cb_ok <= 1'b0; from_low <= 1'b0;
    end else if (ce_n && !busy) begin
      seq <= SQ_IDLE;
      cnt <= '0;
    end else if (cmd_hit && busy) begin
      if (kind == CK_RST) begin
        start_q <= 1'b1; op_q <= OP_RESET; ptr <= AR_LOW;
        seq <= SQ_IDLE; cnt <= '0; cb_ok <= 1'b0;
      end else if (kind == CK_STAT) begin
        start_q <= 1'b1; op_q <= OP_STAT;
      end
    end else if (cmd_hit) begin
      if (kind != CK_STAT) cb_ok <= 1'b0;
      cnt <= '0;
      case (kind)
        CK_RD_LOW, CK_RD_HIGH, CK_RD_SPARE: begin
          ptr      <= (kind == CK_RD_LOW)  ? AR_LOW :
                      (kind == CK_RD_HIGH) ? AR_HIGH : AR_SPARE;
          from_low <= (kind == CK_RD_LOW);
          mode     <= MD_READ;
          seq      <= SQ_ADDR;
        end
        CK_PG_SETUP: begin mode <= MD_PROG;  seq <= SQ_ADDR; end
        CK_ER_SETUP: begin mode <= MD_ERASE; seq <= SQ_ADDR; end
        CK_PG_GO: begin
          if (seq == SQ_DATA) begin start_q <= 1'b1; op_q <= OP_PROG; end
          seq <= SQ_IDLE;
        end
        CK_ER_GO: begin
          if (seq == SQ_ECONF) begin start_q <= 1'b1; op_q <= OP_ERASE; end
          seq <= SQ_IDLE;
        end
        CK_CB_GO: begin
          if (seq == SQ_IDLE && cb_ok) begin start_q <= 1'b1; op_q <= OP_COPY; end
          seq <= SQ_IDLE;
        end
        CK_ID:  begin start_q <= 1'b1; op_q <= OP_RDID; seq <= SQ_IDLE; end
        CK_RST: begin start_q <= 1'b1; op_q <= OP_RESET; ptr <= AR_LOW; seq <= SQ_IDLE; end
        CK_STAT: begin start_q <= 1'b1; op_q <= OP_STAT; cnt <= cnt; end
        default: seq <= SQ_IDLE;
      endcase
    end else if (addr_ld) begin
      cnt <= cnt + 1'b1;
      if (last_slot) begin
        case (mode)
          MD_READ: begin
            start_q <= 1'b1; op_q <= OP_READ; seq <= SQ_IDLE; cb_ok <= from_low;
          end
          MD_PROG: seq <= SQ_DATA;
          default: seq <= SQ_ECONF;
        endcase
      end
    end
  end

  assign op_start = start_q;
  assign op_code  = op_q;
  assign op_area  = ptr;
endmodule

// File: rtl/nfe_checker.sv
module nfe_checker
  import nfe_pkg::*;
#(
  parameter int ROW_BYTES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_n,
  input logic             busy,
  input logic             op_start,
  input logic [2:0]       op_code,
  input logic [1:0]       op_area,
  input logic [BYTE_W-1:0] op_col
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !op_start);
  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst) op_start |=> !op_start);
  // R11
  ce_taken_chk: assert property (@(posedge clk) disable iff (rst) op_start |-> $past(!ce_n));
  // R7
  busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (op_start && $past(busy)) |-> (op_code == OP_RESET || op_code == OP_STAT));
  // R4
  erase_col_chk: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_code == OP_ERASE) |-> (op_col == '0));
  // R6
  reset_area_chk: assert property (@(posedge clk) disable iff (rst)
    (op_start && op_code == OP_RESET) |-> (op_area == 2'd0));
  // R2
  area_legal_chk: assert property (@(posedge clk) disable iff (rst) op_area != 2'd3);
  // R11
  code_valid_chk: assert property (@(posedge clk) disable iff (rst) op_start |-> (op_code != OP_NONE));
endmodule

bind nand_cmd_front nfe_checker #(.ROW_BYTES(ROW_BYTES)) i_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .busy(busy), .op_start(op_start),
  .op_code(op_code), .op_area(op_area), .op_col(op_col)
);

// File: tb/test_nand_cmd_front.sv
module test_nand_cmd_front;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, busy = 1'b0;
  logic [7:0] io_in = 8'h00;
  logic op_start;
  logic [2:0] op_code;
  logic [1:0] op_area;
  logic [7:0] op_col;
  logic [15:0] op_row;
  int n_chk = 0, n_bad = 0;
  logic [1:0] ptr_m = 2'd0;

  always #10 clk = ~clk;

  nand_cmd_front i_nand_cmd_front (
    .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .io_in(io_in), .busy(busy), .op_start(op_start), .op_code(op_code),
    .op_area(op_area), .op_col(op_col), .op_row(op_row)
  );

  function automatic logic [15:0] row_of(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [1:0] area_of(input logic [7:0] opc);
    return (opc == 8'h01) ? 2'd1 : (opc == 8'h50) ? 2'd2 : 2'd0;
  endfunction

  task automatic wr(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk); cle = c; ale = a; io_in = b; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(posedge clk); #2;
  endtask

  task automatic none(input string req);
    n_chk++;
    if (op_start !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: op_start=%b code=%0d expected no start", req, op_start, op_code);
    end
  endtask

  task automatic expect_op(input string req, input logic [2:0] c, input logic [1:0] ar,
                           input logic [7:0] col, input logic [15:0] row, input bit chk_addr);
    n_chk++;
    if (op_start !== 1'b1 || op_code !== c || op_area !== ar ||
        (chk_addr && (op_col !== col || op_row !== row))) begin
      n_bad++;
      $display("FAIL %s: start=%b code=%0d area=%0d col=%h row=%h expected start=1 code=%0d area=%0d col=%h row=%h",
               req, op_start, op_code, op_area, op_col, op_row, c, ar, col, row);
    end
  endtask

  task automatic do_read(input string req, input logic [7:0] opc, input logic [7:0] c,
                         input logic [7:0] lo, input logic [7:0] hi);
    wr(1, 0, opc); none(req);
    ptr_m = area_of(opc);
    wr(0, 1, c);  none(req);
    wr(0, 1, lo); none(req);
    wr(0, 1, hi); expect_op(req, 3'd1, ptr_m, c, row_of(lo, hi), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    // R1 during reset
    none("R1");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    none("R1");
    n_chk++;
    if (op_area !== 2'd0) begin
      n_bad++; $display("FAIL R1: area=%0d expected 0", op_area);
    end

    // R2 read in each area
    do_read("R2", 8'h00, 8'h12, 8'h34, 8'h56);
    // R8 extra address ignored
    wr(0, 1, 8'h99); none("R8");
    // R5 copy-back after 00h read
    wr(1, 0, 8'h8A); expect_op("R5", 3'd3, 2'd0, 8'h12, 16'h5634, 1);
    do_read("R2", 8'h01, 8'h0F, 8'hA0, 8'h01);
    do_read("R2", 8'h50, 8'h05, 8'h11, 8'h22);
    // R9 copy-back after a non-00h read is an orphan
    wr(1, 0, 8'h8A); none("R9");

    // R3 program with data bytes, R8 extra address
    wr(1, 0, 8'h80); none("R3");
    wr(0, 1, 8'h40); wr(0, 1, 8'h41); wr(0, 1, 8'h42); none("R3");
    wr(0, 1, 8'h77); none("R8");
    wr(0, 0, 8'h10); none("R3");
    wr(0, 0, 8'hFF); none("R3");
    wr(1, 0, 8'h10); expect_op("R3", 3'd2, 2'd2, 8'h40, 16'h4241, 1);

    // R9 orphans and undefined opcode
    wr(1, 0, 8'h10); none("R9");
    wr(1, 0, 8'hD0); none("R9");
    wr(1, 0, 8'h80); wr(0, 1, 8'h01); wr(0, 1, 8'h02); wr(0, 1, 8'h03);
    wr(1, 0, 8'h33); none("R9");
    wr(1, 0, 8'h10); none("R9");

    // R4 erase
    wr(1, 0, 8'h60); wr(0, 1, 8'hAB); none("R4");
    wr(0, 1, 8'hCD); none("R4");
    wr(1, 0, 8'hD0); expect_op("R4", 3'd4, 2'd2, 8'h00, 16'hCDAB, 1);

    // R6 single-cycle commands
    wr(1, 0, 8'h70); expect_op("R6", 3'd7, 2'd2, 8'h00, 16'h0, 0);
    wr(1, 0, 8'h90); expect_op("R6", 3'd5, 2'd2, 8'h00, 16'h0, 0);
    wr(1, 0, 8'hFF); expect_op("R6", 3'd6, 2'd0, 8'h00, 16'h0, 0);
    ptr_m = 2'd0;

    // R7 busy filters commands
    @(negedge clk); busy = 1'b1;
    wr(1, 0, 8'h80); none("R7");
    wr(1, 0, 8'h01); none("R7");
    wr(1, 0, 8'h70); expect_op("R7", 3'd7, 2'd0, 8'h00, 16'h0, 0);
    @(negedge clk); busy = 1'b0;
    wr(0, 1, 8'h01); wr(0, 1, 8'h02); wr(0, 1, 8'h03);
    wr(1, 0, 8'h10); none("R7");
    // R7 address and ce_n high ignored while busy, sequence kept
    wr(1, 0, 8'h00); wr(0, 1, 8'h5A);
    @(negedge clk); busy = 1'b1;
    wr(0, 1, 8'hEE); none("R7");
    @(negedge clk); ce_n = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b0; busy = 1'b0;
    wr(0, 1, 8'h21); none("R7");
    wr(0, 1, 8'h43); expect_op("R7", 3'd1, 2'd0, 8'h5A, 16'h4321, 1);
    @(negedge clk); busy = 1'b1;
    wr(1, 0, 8'hFF); expect_op("R7", 3'd6, 2'd0, 8'h00, 16'h0, 0);
    @(negedge clk); busy = 1'b0;

    // R10 ce_n abort
    wr(1, 0, 8'h00); wr(0, 1, 8'h10);
    @(negedge clk); ce_n = 1'b1;
    repeat (2) @(negedge clk);
    ce_n = 1'b0;
    wr(0, 1, 8'h20); wr(0, 1, 8'h30); none("R10");
    wr(0, 1, 8'h40); none("R10");

    // R11 ce_n high and both latches high
    @(negedge clk); ce_n = 1'b1;
    wr(1, 0, 8'hFF); none("R11");
    @(negedge clk); ce_n = 1'b0;
    wr(1, 1, 8'h70); none("R11");
    @(posedge clk); #2; none("R11");

    // random sequences
    for (int i = 0; i < 40; i++) begin
      int k;
      logic [7:0] c, lo, hi;
      k = $urandom % 5;
      c = 8'($urandom); lo = 8'($urandom); hi = 8'($urandom);
      if (k == 0) do_read("R2", 8'h00, c, lo, hi);
      else if (k == 1) do_read("R2", 8'h01, c, lo, hi);
      else if (k == 2) do_read("R2", 8'h50, c, lo, hi);
      else if (k == 3) begin
        wr(1, 0, 8'h80); wr(0, 1, c); wr(0, 1, lo); wr(0, 1, hi);
        for (int d = 0; d < int'($urandom % 4); d++) wr(0, 0, 8'($urandom));
        wr(1, 0, 8'h10); expect_op("R3", 3'd2, ptr_m, c, row_of(lo, hi), 1);
      end else begin
        wr(1, 0, 8'h60); wr(0, 1, lo); wr(0, 1, hi);
        wr(1, 0, 8'hD0); expect_op("R4", 3'd4, ptr_m, 8'h00, row_of(lo, hi), 1);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule